// File: doc/BRIEF.md
# Sorted Key Binary Search Engine

This block answers one question about a fixed table of 32-bit keys stored in ascending order: is a given query value present, and if so, at which position? The table is a read-only memory whose contents are set when the design is built. A search starts with a one-cycle start pulse that captures the query. The engine then narrows a pair of lower and upper bounds by repeated halving until it hits the key or the bounds cross.

The table is read at exactly one address per clock cycle through a registered read port, so it can be mapped onto a single-port block memory rather than a wide register array. Each probe takes two cycles: one to issue the midpoint address and one to compare the returned word. A one-cycle done pulse closes the search. Found and index then hold their values until a later search completes. In the default build, entry i holds `KEY_BASE + KEY_STEP * i`, which is 32'h7FFF_F000 + 16·i for 3872 entries. The keys cross the 32'h8000_0000 boundary, so the unsigned ordering of the table is exercised.

Top module: `sorted_key_finder`

## Requirements
- R1: While reset is held and in the first cycles after it is released, busy_o and done_o are 0, found_o is 0 and index_o is all ones.
- R2: When the query equals table entry i (entry i = KEY_BASE + KEY_STEP·i, default 32'h7FFF_F000 + 16·i), the search completes with found_o = 1 and index_o = i.
- R3: When the query equals no entry, the search completes with found_o = 0 and index_o all ones (4095 for the default 12-bit index). This covers a query below the first entry, above the last entry, or between two entries. Key ordering is unsigned over all 32 bits.
- R4: Both table ends are reachable: the first entry gives index 0 and the last entry gives index DEPTH-1. The read address never leaves 0..DEPTH-1, even when the upper bound drops below zero.
- R5: done_o is high for exactly one cycle per search. After done_o, found_o and index_o keep their values until the next search completes.
- R6: A start pulse arriving while busy_o is high is ignored. The running search finishes with the result for the query captured at its own start.
- R7: done_o rises no later than 2·PROBES+1 = 25 cycles after the clock edge that accepts start. A query equal to the entry at the first midpoint, index (DEPTH-1)/2 = 1935, completes 2 cycles after that edge.
- R8: busy_o rises on the clock edge that accepts start and falls on the edge that raises done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start_i | input | 1 | One-cycle request to begin a search; sampled only when idle |
| query_i | input | KEY_W | Value to look for, captured with an accepted start |
| busy_o | output | 1 | High while a search is in progress |
| done_o | output | 1 | One-cycle pulse when a search completes |
| found_o | output | 1 | 1 if the last completed search hit a table entry |
| index_o | output | AW | Position of the hit, or all ones when not found |

## Verification
A wrong bound update, such as an off-by-one step or a midpoint that wraps, does not show as a wrong table read. It shows as a wrong index or a false miss on keys near the table ends or at particular depths of the search tree. Those keys are queried directly, and every error appears at the one done pulse, within 25 cycles of start. A state machine that stalls or restarts is caught by the cycle count between start and done. A result register that changes when it should not is caught by watching found and index over idle cycles after done.

// File: rtl/skf_pkg.sv
package skf_pkg;

  // Controller phases: idle, drive the midpoint address, judge the read word.
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_JUDGE = 2'd2
  } skf_state_e;

  // Relation of the probed table word to the query.
  typedef enum logic [1:0] {
    REL_BELOW = 2'd0,
    REL_EQUAL = 2'd1,
    REL_ABOVE = 2'd2
  } skf_rel_e;

endpackage

// File: rtl/skf_rom.sv
// Read-only key table with a registered single-port read.
// Contents are a build-time arithmetic progression, so no file is needed.
module skf_rom #(
  parameter int              DEPTH    = 3872,
  parameter int              KEY_W    = 32,
  parameter int              AW       = 12,
  parameter logic [KEY_W-1:0] KEY_BASE = 32'h7FFF_F000,
  parameter logic [KEY_W-1:0] KEY_STEP = 32'd16
) (
  input  logic             clk,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_addr,
  output logic [KEY_W-1:0] rd_data
);

  function automatic logic [KEY_W-1:0] entry_of(input logic [AW-1:0] pos);
    logic [KEY_W-1:0] wide_pos;
    wide_pos = KEY_W'(pos);
    return KEY_BASE + KEY_STEP * wide_pos;
  endfunction

  // One location per cycle, data valid the cycle after the address.
  always_ff @(posedge clk) begin
    if (rd_en) begin
      rd_data <= entry_of(rd_addr);
    end
  end

endmodule

// File: rtl/skf_bounds.sv
// Low/high search bounds held one bit wider and signed, so that
// "midpoint minus one" at position zero becomes -1 instead of wrapping.
module skf_bounds #(
  parameter int DEPTH = 3872,
  parameter int AW    = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          init,
  input  logic          raise_lo,
  input  logic          drop_hi,
  output logic [AW-1:0] mid_o,
  output logic          crossed_o
);

  localparam int BW = AW + 1;
  localparam logic signed [BW-1:0] LAST = BW'(DEPTH - 1);
  localparam logic signed [BW-1:0] ONE  = BW'(1);

  logic signed [BW-1:0] lo_q, hi_q, lo_d, hi_d;
  logic signed [BW:0]   sum;
  logic signed [BW-1:0] mid_ext;
  logic [1:0]           unused_bits;

  assign sum         = {lo_q[BW-1], lo_q} + {hi_q[BW-1], hi_q};
  assign mid_ext     = sum[BW:1];
  assign mid_o       = mid_ext[AW-1:0];
  assign unused_bits = {sum[0], mid_ext[BW-1]};
  assign crossed_o   = (lo_q > hi_q);

  always_comb begin
    lo_d = lo_q;
    hi_d = hi_q;
    if (init) begin
      lo_d = '0;
      hi_d = LAST;
    end else begin
      if (raise_lo) lo_d = mid_ext + ONE;
      if (drop_hi)  hi_d = mid_ext - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= LAST;
    end else begin
      lo_q <= lo_d;
      hi_q <= hi_d;
    end
  end

endmodule

// File: rtl/skf_fsm.sv
// Search sequencer: alternates issue and judge phases, one table read per probe.
module skf_fsm
  import skf_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start,
  input  logic     crossed,
  input  skf_rel_e rel,
  output logic     busy,
  output logic     capture,
  output logic     init,
  output logic     rd_en,
  output logic     raise_lo,
  output logic     drop_hi,
  output logic     finish,
  output logic     hit
);

  skf_state_e state_q, state_d;

  always_comb begin
    state_d  = state_q;
    capture  = 1'b0;
    init     = 1'b0;
    rd_en    = 1'b0;
    raise_lo = 1'b0;
    drop_hi  = 1'b0;
    finish   = 1'b0;
    hit      = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          capture = 1'b1;
          init    = 1'b1;
          state_d = ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        if (crossed) begin
          finish  = 1'b1;
          state_d = ST_IDLE;
        end else begin
          rd_en   = 1'b1;
          state_d = ST_JUDGE;
        end
      end
      ST_JUDGE: begin
        unique case (rel)
          REL_EQUAL: begin
            finish  = 1'b1;
            hit     = 1'b1;
            state_d = ST_IDLE;
          end
          REL_BELOW: begin
            raise_lo = 1'b1;
            state_d  = ST_ISSUE;
          end
          default: begin
            drop_hi = 1'b1;
            state_d = ST_ISSUE;
          end
        endcase
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign busy = (state_q != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/sorted_key_finder.sv
module sorted_key_finder
  import skf_pkg::*;
#(
  parameter int               DEPTH    = 3872,
  parameter int               KEY_W    = 32,
  parameter int               AW       = $clog2(DEPTH),
  parameter logic [KEY_W-1:0] KEY_BASE = 32'h7FFF_F000,
  parameter logic [KEY_W-1:0] KEY_STEP = 32'd16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [KEY_W-1:0] query_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             found_o,
  output logic [AW-1:0]    index_o
);

  localparam int SYNC_STAGES = 2;

  // Reset: asserted asynchronously, released on the clock.
  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[SYNC_STAGES-1];

  logic             capture, init, rd_en, raise_lo, drop_hi, finish, hit;
  logic             crossed;
  logic [AW-1:0]    mid;
  logic [KEY_W-1:0] query_q, rd_data;
  skf_rel_e         rel;

  skf_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .start    (start_i),
    .crossed  (crossed),
    .rel      (rel),
    .busy     (busy_o),
    .capture  (capture),
    .init     (init),
    .rd_en    (rd_en),
    .raise_lo (raise_lo),
    .drop_hi  (drop_hi),
    .finish   (finish),
    .hit      (hit)
  );

  skf_bounds #(.DEPTH(DEPTH), .AW(AW)) u_bounds (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .init      (init),
    .raise_lo  (raise_lo),
    .drop_hi   (drop_hi),
    .mid_o     (mid),
    .crossed_o (crossed)
  );

  skf_rom #(
    .DEPTH(DEPTH), .KEY_W(KEY_W), .AW(AW),
    .KEY_BASE(KEY_BASE), .KEY_STEP(KEY_STEP)
  ) u_rom (
    .clk     (clk),
    .rd_en   (rd_en),
    .rd_addr (mid),
    .rd_data (rd_data)
  );

  // Query register, loaded only by an accepted start.
  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int)   query_q <= '0;
    else if (capture) query_q <= query_i;
  end

  // Unsigned ordering of the probed word against the query.
  always_comb begin
    if (rd_data < query_q)      rel = REL_BELOW;
    else if (rd_data > query_q) rel = REL_ABOVE;
    else                        rel = REL_EQUAL;
  end

  // Result registers: updated only when a search ends.
  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      done_o  <= 1'b0;
      found_o <= 1'b0;
      index_o <= '1;
    end else begin
      done_o <= finish;
      if (finish) begin
        found_o <= hit;
        index_o <= hit ? mid : '1;
      end
    end
  end

endmodule

// File: rtl/skf_checker.sv
module skf_checker #(
  parameter int DEPTH = 3872,
  parameter int AW    = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          found_o,
  input logic [AW-1:0] index_o,
  input logic          rd_en,
  input logic [AW-1:0] rd_addr
);

  localparam int PROBES  = $clog2(DEPTH + 1);
  localparam int MAX_CYC = 2 * PROBES + 1;
  localparam int CW      = $clog2(MAX_CYC + 2) + 1;

  logic [CW-1:0] busy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      busy_cnt <= '0;
    else if (busy_o) busy_cnt <= busy_cnt + 1'b1;
    else             busy_cnt <= '0;
  end

  // R2: a hit always names a real table slot
  a_r2_hit_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && found_o) |-> (index_o < AW'(DEPTH)));

  // R3: a miss carries the all-ones code
  a_r3_miss_code: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !found_o) |-> (index_o == '1));

  // R4: table reads stay inside the table
  a_r4_addr_in_table: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (rd_addr < AW'(DEPTH)));

  // R5: done lasts one cycle
  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R5: result holds while idle with no new request
  a_r5_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> ($stable(found_o) && $stable(index_o)));

  // R6: a search only ends through done, never aborted by a late start
  a_r6_end_via_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);

  // R7: bounded search length
  a_r7_latency_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (busy_cnt < CW'(MAX_CYC)));

  // R8: accepted start raises busy
  a_r8_busy_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o);

endmodule

bind sorted_key_finder skf_checker #(.DEPTH(DEPTH), .AW(AW)) u_skf_checker (
  .clk     (clk),
  .rst_n   (rst_n_int),
  .start_i (start_i),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .found_o (found_o),
  .index_o (index_o),
  .rd_en   (rd_en),
  .rd_addr (mid)
);

// File: tb/tb_sorted_key_finder.sv
module tb_sorted_key_finder;

  localparam int          DEPTH    = 3872;
  localparam int          AW       = 12;
  localparam logic [31:0] KEY_BASE = 32'h7FFF_F000;
  localparam logic [31:0] KEY_STEP = 32'd16;
  localparam int          MAX_CYC  = 25;
  localparam int          NV       = 12;

  localparam logic [31:0] QV [NV] = '{
    KEY_BASE,                           // first entry
    KEY_BASE + KEY_STEP * 32'd3871,     // last entry
    KEY_BASE + KEY_STEP * 32'd1935,     // first midpoint
    KEY_BASE + KEY_STEP * 32'd256,      // 32'h8000_0000
    KEY_BASE + KEY_STEP * 32'd255,      // just below bit-31 boundary
    KEY_BASE + KEY_STEP * 32'd3000,
    KEY_BASE + KEY_STEP * 32'd1000 + 32'd1, // between entries
    32'h0000_0000,
    32'hFFFF_FFFF,
    KEY_BASE - 32'd1,                   // below first
    KEY_BASE + KEY_STEP * 32'd3871 + 32'd1, // above last
    KEY_BASE + KEY_STEP * 32'd1
  };

  logic          clk, rst_n, start_i;
  logic [31:0]   query_i;
  logic          busy_o, done_o, found_o;
  logic [AW-1:0] index_o;

  int n_chk, n_fail;

  sorted_key_finder dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .query_i(query_i),
    .busy_o(busy_o), .done_o(done_o), .found_o(found_o), .index_o(index_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [31:0] key_at(input int i);
    return KEY_BASE + KEY_STEP * 32'(i);
  endfunction

  // Expected {found, index} from the table rule alone.
  function automatic logic [AW:0] expect_of(input logic [31:0] q);
    logic [31:0] off;
    if (q < KEY_BASE) return {1'b0, {AW{1'b1}}};
    off = q - KEY_BASE;
    if ((off % KEY_STEP) != 0) return {1'b0, {AW{1'b1}}};
    if ((off / KEY_STEP) >= 32'(DEPTH)) return {1'b0, {AW{1'b1}}};
    return {1'b1, AW'(off / KEY_STEP)};
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_done(output int cyc);
    cyc = 0;
    while (!done_o && cyc < 100) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic search(input logic [31:0] q, output logic f,
                        output logic [AW-1:0] idx, output int cyc);
    start_i = 1'b1;
    query_i = q;
    @(negedge clk);
    start_i = 1'b0;
    query_i = '0;
    wait_done(cyc);
    f   = found_o;
    idx = index_o;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic          f;
    logic [AW-1:0] idx;
    logic [AW:0]   e;
    int            cyc;
    string         tag;
    n_chk = 0;
    n_fail = 0;
    rst_n = 1'b0;
    start_i = 1'b0;
    query_i = '0;
    repeat (3) @(negedge clk);
    // R1 during reset
    check(!busy_o && !done_o && !found_o && index_o == '1, "R1 in reset",
          {found_o, busy_o, done_o, index_o}, {3'b000, {AW{1'b1}}});
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(busy_o == 1'b0, "R1 busy", busy_o, 0);
    check(done_o == 1'b0, "R1 done", done_o, 0);
    check(found_o == 1'b0, "R1 found", found_o, 0);
    check(index_o == '1, "R1 index", index_o, {AW{1'b1}});

    // Vector walk: R2 hits, R3 misses, R4 table ends, R7 bound
    for (int v = 0; v < NV; v++) begin
      e = expect_of(QV[v]);
      search(QV[v], f, idx, cyc);
      if (!e[AW])                                  tag = "R3";
      else if (e[AW-1:0] == 0 || e[AW-1:0] == AW'(DEPTH - 1)) tag = "R4";
      else                                         tag = "R2";
      check(f == e[AW] && idx == e[AW-1:0], tag, {f, idx}, e);
      check(cyc <= MAX_CYC, "R7 latency bound", cyc, MAX_CYC);
      @(negedge clk);
    end

    // R7: first-midpoint hit completes in two cycles
    search(key_at(1935), f, idx, cyc);
    check(cyc == 2, "R7 midpoint latency", cyc, 2);
    @(negedge clk);

    // R5: single-cycle done, result holds afterwards
    search(key_at(100), f, idx, cyc);
    check(f && idx == AW'(100), "R2 key 100", {f, idx}, {1'b1, AW'(100)});
    @(negedge clk);
    check(done_o == 1'b0, "R5 done one cycle", done_o, 0);
    repeat (6) @(negedge clk);
    check(found_o == 1'b1 && index_o == AW'(100), "R5 result held",
          {found_o, index_o}, {1'b1, AW'(100)});

    // R8: busy rises with accepted start, falls with done
    start_i = 1'b1;
    query_i = key_at(2);
    @(negedge clk);
    start_i = 1'b0;
    check(busy_o == 1'b1, "R8 busy after start", busy_o, 1);
    wait_done(cyc);
    check(busy_o == 1'b0 && done_o == 1'b1, "R8 busy low at done",
          {busy_o, done_o}, 2'b01);
    @(negedge clk);

    // R6: start while busy is ignored
    start_i = 1'b1;
    query_i = key_at(500);
    @(negedge clk);
    start_i = 1'b1;
    query_i = key_at(7);
    @(negedge clk);
    start_i = 1'b0;
    query_i = '0;
    wait_done(cyc);
    check(found_o && index_o == AW'(500), "R6 late start ignored",
          {found_o, index_o}, {1'b1, AW'(500)});
    check(cyc <= MAX_CYC - 1, "R7 latency with late start", cyc + 1, MAX_CYC);
    repeat (3) @(negedge clk);
    check(busy_o == 1'b0 && index_o == AW'(500), "R6 no second search",
          {busy_o, index_o}, {1'b0, AW'(500)});

    // R3 then R5: a miss overwrites, then holds
    search(key_at(20) + 32'd8, f, idx, cyc);
    check(!f && idx == '1, "R3 gap miss", {f, idx}, {1'b0, {AW{1'b1}}});
    repeat (4) @(negedge clk);
    check(!found_o && index_o == '1, "R5 miss held",
          {found_o, index_o}, {1'b0, {AW{1'b1}}});

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule